// File: doc/BRIEF.md
# Byte-Serial CRC-16 Frame Check Engine

This block computes the 16-bit frame check sequence of a serial link one byte at a time. A host writes each byte into an input register. The engine folds that byte into a running 16-bit remainder in the same clock, and a byte counter advances by one. The host can send bytes on consecutive cycles.

A control register does two jobs. Writing a one to its top bit restarts the computation by reseeding the remainder and zeroing the counter. Reading it returns the number of bytes taken in since the last restart. A separate result register returns the finished check value, which is the complement of the remainder.

The arithmetic uses the CCITT polynomial x^16+x^12+x^5+1, processed least significant bit first, with the remainder seeded to 0xFFFF and the output inverted. After a restart, the bytes 0xCC, 0xF5, 0xF1, 0xA7 give a count of 4 and a result of 0x51DF. A driver can use this sequence as a power-on self-test.

Top module: `crc16_byte_engine`

## Requirements
- R1: After the reset input is released, the control register reads a count of 0 and the result register reads 0x0000.
- R2: A write to the control register (address 0) with bit 15 set sets the remainder back to 0xFFFF and the count to 0. Bit 15 always reads back as 0.
- R3: A write to the control register with bit 15 clear changes neither the count nor the result.
- R4: A write to the input register (address 1) uses only bits 7:0 of the written word. Bits 15:8 have no effect on the result.
- R5: Each input-register write raises the count, read from control bits 11:0, by exactly one. The control bits above the count read as 0.
- R6: After a restart, the bytes 0xCC, 0xF5, 0xF1, 0xA7 give a count of 4 and a result of 0x51DF.
- R7: Input-register writes on consecutive clock cycles are each taken in, with no idle cycle needed between them.
- R8: The count stops at 4095 and stays there while further bytes arrive. The remainder keeps updating.
- R9: The result register (address 2) reads the bitwise complement of the remainder. Each byte is folded into the remainder with the reflected polynomial 0x8408, least significant bit first.
- R10: Read data appears on rdata in the cycle after rd_en and holds until the next read. Reads of the input register or of the unused address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| rd_en | input | 1 | Read strobe for the register at addr |
| addr | input | ADDR_W (2) | Register select: 0 control, 1 input byte, 2 result |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
The bench builds the engine with its default parameters: a 12-bit counter and a 2-bit address. Saturation is therefore reached after 4095 bytes, and a burst of 4100 consecutive writes pushes the counter past its limit within a short run. The same default width makes a sweep over all 256 byte values practical. Each byte is sent alone after a restart, with junk in the upper half of the word. Every result is compared against a bit-by-bit shift model written in the bench, which is a different formulation from the nibble-folding function in the RTL.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned DATA_ADDR   = 1;
  localparam int unsigned RESULT_ADDR = 2;
  localparam int unsigned CLR_BIT     = 15;

  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_XOROUT = 16'hFFFF;

  // Fold one byte into a reflected CCITT remainder (poly 0x8408),
  // written in the eight-bits-at-once nibble form.
  function automatic logic [15:0] crc_fold_byte(input logic [15:0] rem,
                                                input logic [7:0]  din);
    logic [7:0] x;
    x = rem[7:0] ^ din;
    x = x ^ {x[3:0], 4'b0000};
    return {8'h00, rem[15:8]} ^ {x, 8'h00} ^ {5'b00000, x, 3'b000}
           ^ {12'h000, x[7:4]};
  endfunction

  function automatic logic [15:0] crc_finish(input logic [15:0] rem);
    return rem ^ CRC_XOROUT;
  endfunction

endpackage

// File: rtl/crc16_remainder.sv
module crc16_remainder
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        load_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] rem_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_o <= CRC_SEED;
    else if (clr_i)  rem_o <= CRC_SEED;
    else if (load_i) rem_o <= crc_fold_byte(rem_o, byte_i);
  end

  // R2: a clear reseeds the remainder
  a_r2_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> rem_o == CRC_SEED);

  // R3: no clear and no byte means no change
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i) |=> $stable(rem_o));

endmodule

// File: rtl/crc16_byte_counter.sv
module crc16_byte_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max = (cnt_o == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (inc_i && !at_max) cnt_o <= cnt_o + 1'b1;
  end

  a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_o == '0);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);

endmodule

// File: rtl/crc16_reg_decode.sv
module crc16_reg_decode
  import crc16_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [15:0]       rem_i,
  output logic              clr_o,
  output logic              load_o,
  output logic [7:0]        byte_o,
  output logic [15:0]       rdata
);

  localparam int PAD_W = 16 - CNT_W;

  logic sel_ctrl, sel_data, sel_result;
  logic [15:0] rd_next;

  assign sel_ctrl   = (addr == ADDR_W'(CTRL_ADDR));
  assign sel_data   = (addr == ADDR_W'(DATA_ADDR));
  assign sel_result = (addr == ADDR_W'(RESULT_ADDR));

  assign clr_o  = wr_en && sel_ctrl && wdata[CLR_BIT];
  assign load_o = wr_en && sel_data;
  assign byte_o = wdata[7:0];

  always_comb begin
    rd_next = 16'h0000;
    if (sel_ctrl)        rd_next = {{PAD_W{1'b0}}, cnt_i};
    else if (sel_result) rd_next = crc_finish(rem_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 16'h0000;
    else if (rd_en) rdata <= rd_next;
  end

  // R10: read data holds between reads
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
  import crc16_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);

  logic             eng_clr;
  logic             eng_load;
  logic [7:0]       eng_byte;
  logic [15:0]      eng_rem;
  logic [CNT_W-1:0] eng_cnt;

  crc16_reg_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .cnt_i  (eng_cnt),
    .rem_i  (eng_rem),
    .clr_o  (eng_clr),
    .load_o (eng_load),
    .byte_o (eng_byte),
    .rdata  (rdata)
  );

  crc16_remainder u_rem (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (eng_clr),
    .load_i (eng_load),
    .byte_i (eng_byte),
    .rem_o  (eng_rem)
  );

  crc16_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (eng_clr),
    .inc_i  (eng_load),
    .cnt_o  (eng_cnt)
  );

  // R3: control write without the clear bit leaves all state untouched
  a_r3_ctrl_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CTRL_ADDR) && !wdata[CLR_BIT])
      |=> ($stable(eng_cnt) && $stable(eng_rem)));

  // R7: every data write lands in the counter, even back to back
  a_r7_burst_count: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_load && $past(eng_load) && eng_cnt != {CNT_W{1'b1}})
      |=> eng_cnt != $past(eng_cnt));

endmodule

// File: tb/crc16_byte_engine_tb_top.sv
`timescale 1ns/1ps
module crc16_byte_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] model;
  int          mcount;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  crc16_byte_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [15:0] bit_model(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic restart();
    wr(2'd0, 16'h8000);
    model = 16'hFFFF; mcount = 0;
  endtask

  task automatic feed(input logic [15:0] d);
    wr(2'd1, d);
    model = bit_model(model, d[7:0]);
    if (mcount < 4095) mcount++;
  endtask

  task automatic burst(input int n, input int seed);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd1;
    for (int i = 0; i < n; i++) begin
      wdata = 16'((i * 37 + seed) & 16'hFFFF);
      wdata[15:8] = 8'(i * 11);
      model = bit_model(model, wdata[7:0]);
      if (mcount < 4095) mcount++;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, v); check("R1 count", v, 16'h0000);
    rd(2'd2, v); check("R1 result", v, 16'h0000);

    // R6: power-on check vector
    restart();
    feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
    rd(2'd0, v); check("R6 count", v, 16'd4);
    rd(2'd2, v); check("R6 result", v, 16'h51DF);

    // R3: control write without bit 15 changes nothing
    wr(2'd0, 16'h7FFF);
    rd(2'd0, v); check("R3 count", v, 16'd4);
    rd(2'd2, v); check("R3 result", v, 16'h51DF);

    // R2: clear bit resets; bit 15 reads 0
    wr(2'd0, 16'h8000);
    rd(2'd0, v); check("R2 count and bit15", v, 16'h0000);
    rd(2'd2, v); check("R2 result", v, 16'h0000);

    // R10: unused and input addresses read 0; rdata holds without rd_en
    rd(2'd1, v); check("R10 data addr", v, 16'h0000);
    restart(); feed(16'h0055);
    rd(2'd3, v); check("R10 unused addr", v, 16'h0000);
    rd(2'd2, hold);
    feed(16'h0012); feed(16'h0034);
    @(negedge clk);
    check("R10 hold", rdata, hold);

    // R4, R9, R5: sweep every byte value with junk in the high half
    for (int b = 0; b < 256; b++) begin
      restart();
      feed({8'(b ^ 8'hA5), 8'(b)});
      rd(2'd2, v); check("R4 R9 single byte", v, ~model);
      if (b % 64 == 0) begin
        rd(2'd0, v); check("R5 count one", v, 16'd1);
      end
    end

    // R7: back-to-back burst
    restart();
    burst(40, 7);
    rd(2'd0, v); check("R7 burst count", v, 16'd40);
    rd(2'd2, v); check("R7 burst result", v, ~model);

    // R8: saturation while remainder keeps updating
    restart();
    burst(4100, 3);
    rd(2'd0, v); check("R8 saturated count", v, 16'd4095);
    rd(2'd2, v); check("R8 remainder after saturation", v, ~model);
    feed(16'h00C3);
    rd(2'd0, v); check("R8 count stays", v, 16'd4095);
    rd(2'd2, v); check("R8 result still updates", v, ~model);

    // R2: clear out of saturation
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R2 clear from max", v, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule